// File: doc/BRIEF.md
# Multi-Format Serial Bit Line Encoder

This block turns a stream of frame bits, offered one at a time over a valid/ready handshake, into the waveform on a single transmit line. A 4-bit format code picks how each bit is shaped. The choices are several pulse-width and phase formats for radio links, a two-or-three-period style, and pulse-burst versions of that style for infrared links. A per-bit flag can send a bit unencoded (NRZ). In that case its length still follows the chosen format. An external timebase supplies a one-cycle `tick` that advances the waveform by one slot. Frame assembly and clock division stay outside the block.

Each bit is described as a sequence of slots. In each slot the line is either at the idle level or at the active level. With `line_pol` = 0 the line idles low and active slots are high. With `line_pol` = 1 the line idles high and active slots are low. A new bit is taken only on a tick at which the line is idle or the current bit is in its last slot. This lets bits follow each other without a gap.

Top module: `line_bit_encoder`

## Requirements
- R1: Format codes 0110, 1100, 1101, 1110 and 1111 are reserved. While `fmt_sel` holds one of them, `fmt_err` is 1, `bit_rdy` is 0, and no bit is accepted, so the line stays idle. For every other code, `fmt_err` is 0.
- R2: A bit is accepted at a rising edge where `bit_vld`, `bit_rdy` and `tick` are all 1. `bit_rdy` is 1 only when `tick` is 1 and the encoder is idle or in the last slot of its bit. Slot 0 of the new bit is driven from the cycle after acceptance. Each later slot starts after a rising edge with `tick` = 1.
- R3: When no bit is in progress, `tx` equals `line_pol`. In a coded slot, the line is driven to the inverse of `line_pol` when the slot is active.
- R4: Format 0000 (two slots, Manchester): a 0 is active then idle, and a 1 is idle then active.
- R5: Formats 0001 and 0101 use three slots. Under 0001, a 0 is active only in slot 2 and a 1 is active in slots 1 and 2. Under 0101, a 0 is active only in slot 0 and a 1 is active in slots 0 and 1.
- R6: Formats 0010 and 0011 use four slots. Under 0010, a 0 is active in slots 1 and 2 and a 1 is active in slots 0 and 3. Under 0011, a 0 is active in slot 0 and a 1 is active in slots 0 and 1.
- R7: Format 0100: a 1 lasts two slots and a 0 lasts three slots. In both cases only slot 0 is active.
- R8: Format 0111 uses sixteen slots. A 0 is active in slot 0 only, and a 1 is active in slots 0 and 1.
- R9: Codes 1000, 1001, 1010 and 1011 are burst formats. Each uses N pulses of P slots per period, where N = 5 if bit 0 of the code is 0 and N = 8 if it is 1, and P = 3 if bit 1 of the code is 0 and P = 4 if it is 1. A 1 lasts 2·N·P slots and a 0 lasts 3·N·P slots. A slot i is active when i < N·P and i mod P = 0.
- R10: A bit sent with `bit_nrz` = 1 under any valid format other than 0111 holds `tx` equal to the data bit, for the same number of slots the coded bit would take.
- R11: Under format 0111 with `bit_nrz` = 1, a 0 is sent in its coded form. A 1 holds `tx` low for sixteen slots.
- R12: `bit_done` is 1 for exactly the cycle with `tick` = 1 in the last slot of a bit, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slot advance enable from the timebase |
| fmt_sel | input | 4 | Format code, sampled when a bit is accepted |
| bit_vld | input | 1 | A bit is offered |
| bit_val | input | 1 | Data bit |
| bit_nrz | input | 1 | Send this bit unencoded |
| line_pol | input | 1 | Idle level of the line |
| bit_rdy | output | 1 | Bit is taken at this edge if valid |
| tx | output | 1 | Line level |
| bit_done | output | 1 | Last-slot strobe |
| fmt_err | output | 1 | Reserved format selected |

## Verification
`tx` is decoded from registered state without a further register. Its first slot is therefore visible in the cycle right after the acceptance edge, and each slot holds for as many cycles as the tick spacing. `bit_done` and `bit_rdy` are combinational with `tick`, so they fall in the last cycle of a bit. Whenever the driver sees `bit_rdy` just after a falling edge, it queues one expected level per cycle. The monitor compares one queued entry against `tx` and `bit_done` 1 ns after every rising edge. When the queue is empty, the monitor expects the idle level, which makes gaps and reserved codes count as checks too.

// File: rtl/line_bit_encoder.sv
module line_bit_encoder #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] fmt_sel,
  input  logic       bit_vld,
  input  logic       bit_val,
  input  logic       bit_nrz,
  input  logic       line_pol,
  output logic       bit_rdy,
  output logic       tx,
  output logic       bit_done,
  output logic       fmt_err
);

  logic             busy, bit_q, nrz_q, act, last;
  logic [3:0]       fmt_q;
  logic [CNT_W-1:0] cnt, len_q, ir_per;
  logic [1:0]       pcnt, ir_pm1;

  function automatic logic [CNT_W-1:0] bit_len(input logic [3:0] f, input logic b);
    logic [CNT_W-1:0] per;
    per = CNT_W'((f[0] ? 8 : 5) * (f[1] ? 4 : 3));
    case (f)
      4'd0:       bit_len = CNT_W'(2);
      4'd1, 4'd5: bit_len = CNT_W'(3);
      4'd2, 4'd3: bit_len = CNT_W'(4);
      4'd4:       bit_len = b ? CNT_W'(2) : CNT_W'(3);
      4'd7:       bit_len = CNT_W'(16);
      default:    bit_len = b ? (per << 1) : (per + (per << 1));
    endcase
  endfunction

  assign fmt_err  = (fmt_sel == 4'b0110) || (fmt_sel[3:2] == 2'b11);
  assign last     = (cnt == len_q - CNT_W'(1));
  assign bit_done = busy && tick && last;
  assign bit_rdy  = tick && (!busy || last) && !fmt_err;

  assign ir_per = CNT_W'((fmt_q[0] ? 8 : 5) * (fmt_q[1] ? 4 : 3));
  assign ir_pm1 = fmt_q[1] ? 2'd3 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      pcnt  <= '0;
      len_q <= '0;
      fmt_q <= '0;
      bit_q <= 1'b0;
      nrz_q <= 1'b0;
    end else if (bit_vld && bit_rdy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      pcnt  <= '0;
      fmt_q <= fmt_sel;
      bit_q <= bit_val;
      nrz_q <= bit_nrz;
      len_q <= bit_len(fmt_sel, bit_val);
    end else if (bit_done) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      cnt  <= cnt + CNT_W'(1);
      pcnt <= (pcnt == ir_pm1) ? 2'd0 : pcnt + 2'd1;
    end
  end

  always_comb begin
    case (fmt_q)
      4'd0:       act = (cnt == '0) ^ bit_q;
      4'd1:       act = bit_q ? (cnt != '0) : (cnt == CNT_W'(2));
      4'd2:       act = bit_q ? (cnt == '0 || cnt == CNT_W'(3))
                              : (cnt == CNT_W'(1) || cnt == CNT_W'(2));
      4'd3,
      4'd5,
      4'd7:       act = bit_q ? (cnt <= CNT_W'(1)) : (cnt == '0);
      4'd4:       act = (cnt == '0);
      default:    act = (cnt < ir_per) && (pcnt == 2'd0);
    endcase
  end

  always_comb begin
    if (!busy)
      tx = line_pol;
    else if (!nrz_q || (fmt_q == 4'd7 && !bit_q))
      tx = line_pol ^ act;
    else if (fmt_q == 4'd7)
      tx = 1'b0;
    else
      tx = bit_q;
  end

  // R1
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && !busy) |=> !busy);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_rdy) |=> (busy && cnt == '0));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(cnt));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);

endmodule

// File: tb/line_bit_encoder_test.sv
module line_bit_encoder_test;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick;
  logic [3:0] fmt_sel = 4'd0;
  logic       bit_vld = 1'b0, bit_val = 1'b0, bit_nrz = 1'b0, line_pol = 1'b0;
  logic       bit_rdy, tx, bit_done, fmt_err;

  int tick_div = 1, divcnt = 0;
  int errors = 0, checks = 0;
  int expq[$];
  bit mon_on = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) divcnt <= (divcnt >= tick_div - 1) ? 0 : divcnt + 1;
  assign tick = (divcnt == tick_div - 1);

  line_bit_encoder uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_sel(fmt_sel),
    .bit_vld(bit_vld), .bit_val(bit_val), .bit_nrz(bit_nrz), .line_pol(line_pol),
    .bit_rdy(bit_rdy), .tx(tx), .bit_done(bit_done), .fmt_err(fmt_err)
  );

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int e_len(input logic [3:0] f, input logic b);
    int n, p;
    n = f[0] ? 8 : 5;
    p = f[1] ? 4 : 3;
    case (f)
      4'd0: return 2;
      4'd1, 4'd5: return 3;
      4'd2, 4'd3: return 4;
      4'd4: return b ? 2 : 3;
      4'd7: return 16;
      default: return (b ? 2 : 3) * n * p;
    endcase
  endfunction

  function automatic bit e_act(input logic [3:0] f, input logic b, input int i);
    int n, p;
    n = f[0] ? 8 : 5;
    p = f[1] ? 4 : 3;
    case (f)
      4'd0: return (i == 0) ? !b : b;
      4'd1: return b ? (i >= 1) : (i == 2);
      4'd2: return b ? (i == 0 || i == 3) : (i == 1 || i == 2);
      4'd3, 4'd5, 4'd7: return b ? (i < 2) : (i == 0);
      4'd4: return i == 0;
      default: return (i < n * p) && (i % p == 0);
    endcase
  endfunction

  // requirement tag per format: R4 R5 R6 R7 R8 R9, unencoded R10 R11
  function automatic int e_req(input logic [3:0] f, input logic nz);
    if (nz) return (f == 4'd7) ? 11 : 10;
    case (f)
      4'd0: return 4;
      4'd1, 4'd5: return 5;
      4'd2, 4'd3: return 6;
      4'd4: return 7;
      4'd7: return 8;
      default: return 9;
    endcase
  endfunction

  task automatic send(input logic [3:0] f, input logic b, input logic nz);
    int len, req;
    bit lvl, dn;
    @(negedge clk);
    fmt_sel = f; bit_val = b; bit_nrz = nz; bit_vld = 1'b1;
    #1;
    while (!bit_rdy) begin
      @(negedge clk); #1;
    end
    len = e_len(f, b);
    req = e_req(f, nz);
    for (int i = 0; i < len; i++) begin
      if (nz && !(f == 4'd7 && !b)) lvl = (f == 4'd7) ? 1'b0 : b;
      else                           lvl = line_pol ^ e_act(f, b, i);
      for (int k = 0; k < tick_div; k++) begin
        dn = (i == len - 1) && (k == tick_div - 1);
        expq.push_back(req * 4 + int'(dn) * 2 + int'(lvl));
      end
    end
    @(posedge clk);
  endtask

  task automatic stop_wait;
    @(negedge clk);
    bit_vld = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: one expected entry per cycle, idle level when nothing is queued
  initial begin
    forever begin
      @(posedge clk); #1;
      if (mon_on) begin
        if (expq.size() != 0) begin
          int e, r;
          e = expq.pop_front();
          r = e / 4;
          chk(tx == e[0], r, "tx", int'(tx), e[0]);
          chk(bit_done == e[1], 12, "bit_done", int'(bit_done), e[1]); // R12
        end else begin
          chk(tx == line_pol, 3, "idle tx", int'(tx), int'(line_pol)); // R3
          chk(!bit_done, 12, "idle bit_done", int'(bit_done), 0);      // R12
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R3: reset state
    chk(tx == 1'b0, 3, "reset tx", int'(tx), 0);
    chk(!bit_done, 12, "reset bit_done", int'(bit_done), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R6 R7 R8: coded RF formats, polarity low
    foreach (expq[i]) ;
    for (int f = 0; f < 8; f++) begin
      if (f == 6) continue;
      send(4'(f), 1'b0, 1'b0);
      send(4'(f), 1'b1, 1'b0);
      send(4'(f), 1'b1, 1'b0);
      send(4'(f), 1'b0, 1'b0);
      stop_wait();
    end

    // R9: burst formats
    for (int f = 8; f < 12; f++) begin
      send(4'(f), 1'b1, 1'b0);
      send(4'(f), 1'b0, 1'b0);
      stop_wait();
    end

    // R3: inverted polarity
    line_pol = 1'b1;
    repeat (3) @(negedge clk);
    send(4'd0, 1'b1, 1'b0);
    send(4'd3, 1'b0, 1'b0);
    send(4'd9, 1'b1, 1'b0);
    send(4'd7, 1'b1, 1'b0);
    stop_wait();
    line_pol = 1'b0;
    repeat (3) @(negedge clk);

    // R10: unencoded bits keep the coded length
    send(4'd4, 1'b1, 1'b1);
    send(4'd4, 1'b0, 1'b1);
    send(4'd1, 1'b0, 1'b1);
    send(4'd1, 1'b1, 1'b1);
    send(4'd10, 1'b1, 1'b1);
    stop_wait();

    // R11: unencoded under the low-duty format
    send(4'd7, 1'b0, 1'b1);
    send(4'd7, 1'b1, 1'b1);
    send(4'd7, 1'b0, 1'b1);
    stop_wait();

    // R2: slow tick, slots stretch and ready waits for the tick
    tick_div = 3;
    repeat (4) @(negedge clk);
    while (tick) @(negedge clk);
    bit_vld = 1'b1; fmt_sel = 4'd3;
    chk(!bit_rdy, 2, "bit_rdy without tick", int'(bit_rdy), 0);
    send(4'd3, 1'b1, 1'b0);
    send(4'd3, 1'b0, 1'b0);
    send(4'd0, 1'b1, 1'b0);
    stop_wait();
    tick_div = 1;
    repeat (4) @(negedge clk);

    // R1: reserved codes block acceptance and flag an error
    bit_vld = 1'b1; bit_val = 1'b1; bit_nrz = 1'b0;
    fmt_sel = 4'b0110;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(fmt_err == 1'b1, 1, "fmt_err 0110", int'(fmt_err), 1);
      chk(bit_rdy == 1'b0, 1, "bit_rdy 0110", int'(bit_rdy), 0);
    end
    fmt_sel = 4'b1101;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(fmt_err == 1'b1, 1, "fmt_err 1101", int'(fmt_err), 1);
      chk(bit_rdy == 1'b0, 1, "bit_rdy 1101", int'(bit_rdy), 0);
    end
    bit_vld = 1'b0;
    fmt_sel = 4'b0111;
    #1;
    chk(fmt_err == 1'b0, 1, "fmt_err 0111", int'(fmt_err), 0);
    fmt_sel = 4'b1011;
    #1;
    chk(fmt_err == 1'b0, 1, "fmt_err 1011", int'(fmt_err), 0);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule